// File: doc/BRIEF.md
# Shared-Count Physical Register Pool

This block owns the integer physical register pool behind a multi-wide rename stage that can eliminate register-to-register moves. Each physical register carries a small sharing count. A renamed instruction that writes a real integer destination either takes a fresh register from the pool or, when its move is eliminated, adds one reference to the move's physical source register. Committed instructions drop a reference to the register they overwrote. A recovery walk drops a reference to the register that a squashed instruction had received. A register goes back to the pool only when its count reaches zero.

Each cycle the block offers one candidate register per rename slot. The candidates are the lowest-numbered free registers, in ascending order. It also raises a can-allocate flag and exports a per-register saturation vector. The rename stage uses that vector to decide whether a move may be eliminated.

Top module: `rcfl_top`

## Requirements
- R1: After reset, physical registers 0 to 2**LREG_W-1 each hold count 1 and all higher registers are free (count 0). pdest_o lists 2**LREG_W, 2**LREG_W+1, and so on; sat_o is all zero.
- R2: A slot needs a destination only when slot_valid_i, slot_wen_i and a nonzero slot_ldest_i are all true. A slot that does not need one neither takes a register nor touches a count.
- R3: Slots act only in a cycle where can_alloc_o and do_alloc_i are both high. Otherwise no register is taken and no count is raised.
- R4: pdest_o[i] is the i-th lowest free register, or 0 when fewer than i+1 registers are free. When a non-eliminated slot i acts, it takes pdest_o[i] and that register's count becomes 1.
- R5: can_alloc_o is high exactly when at least REN_W registers are free.
- R6: A slot that acts with me_valid_i set takes no register and raises the count of me_psrc_i by one. Its source must not be saturated.
- R7: sat_o[r] is high exactly when register r holds the maximum count, 2**CNT_W-1 (3 by default).
- R8: In normal operation, each valid release slot lowers the count of rel_old_i by one. A register whose count reaches zero is free the next cycle.
- R9: While walk_i is high, each valid release slot lowers the count of rel_new_i instead, and no slot acts.
- R10: While redirect_i is high, no slot acts, but releases still take effect.
- R11: flush_i restores the reset state of R1 on the next edge and discards that cycle's releases.
- R12: Several release slots may target the same register in one cycle. The count then drops by the number of such slots.
- R13: Releasing a register whose count is already zero leaves it free, with count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Restore the reset state |
| redirect_i | input | 1 | Suppress slot actions this cycle |
| walk_i | input | 1 | Recovery walk in progress |
| do_alloc_i | input | 1 | External enable for slot actions |
| slot_valid_i | input | REN_W | Rename slot holds an instruction |
| slot_wen_i | input | REN_W | Slot writes the integer file |
| slot_ldest_i | input | REN_W x LREG_W | Logical destination per slot |
| me_valid_i | input | REN_W | Slot's move is eliminated |
| me_psrc_i | input | REN_W x PW | Physical source of the eliminated move |
| can_alloc_o | output | 1 | Pool holds at least REN_W free registers |
| pdest_o | output | REN_W x PW | Candidate register per slot |
| rel_valid_i | input | CMT_W | Release slot valid |
| rel_new_i | input | CMT_W x PW | Destination given to the retiring instruction |
| rel_old_i | input | CMT_W x PW | Destination it replaced |
| sat_o | output | NUM_PREGS | Per-register count-saturated flag |

## Verification
The bench uses the default build: 64 physical registers, 32 logical registers, four rename slots, four release slots and 2-bit counts. With only 32 registers initially free, the pool runs dry within eight full-width cycles, so can_alloc_o falls and rises often. A count reaches saturation after two eliminations onto the same source, which brings both the saturated and the zero-count boundaries within reach of short directed runs. The random phase then mixes walks, redirects, flushes, repeated releases onto one register and releases of free registers.

// File: rtl/rcfl_pkg.sv
package rcfl_pkg;
  localparam int unsigned DEF_NUM_PREGS = 64;
  localparam int unsigned DEF_LREG_W    = 5;
  localparam int unsigned DEF_REN_W     = 4;
  localparam int unsigned DEF_CMT_W     = 4;
  localparam int unsigned DEF_CNT_W     = 2;

  typedef enum logic [1:0] {
    REL_OLD_DEST = 2'd0,
    REL_NEW_DEST = 2'd1
  } rel_sel_e;
endpackage

// File: rtl/rcfl_pick.sv
module rcfl_pick #(
  parameter int unsigned NUM_PREGS = 64,
  parameter int unsigned REN_W     = 4,
  localparam int unsigned PW = $clog2(NUM_PREGS),
  localparam int unsigned CW = $clog2(NUM_PREGS + 1)
) (
  input  logic [NUM_PREGS-1:0]         free_i,
  output logic [REN_W-1:0][PW-1:0]     pick_o,
  output logic [CW-1:0]                free_cnt_o
);
  // ascending scan: slot s gets the s-th free register
  always_comb begin
    int n;
    n = 0;
    pick_o = '0;
    for (int r = 0; r < NUM_PREGS; r++) begin
      if (free_i[r]) begin
        for (int s = 0; s < REN_W; s++) begin
          if (n == s) pick_o[s] = PW'(r);
        end
        n = n + 1;
      end
    end
    free_cnt_o = CW'(n);
  end
endmodule

// File: rtl/rcfl_cnt_cell.sv
module rcfl_cnt_cell #(
  parameter int unsigned CNT_W = 2,
  parameter int unsigned DEC_W = 3,
  parameter int unsigned INIT  = 0,
  localparam int unsigned SUM_W = ((CNT_W > DEC_W) ? CNT_W : DEC_W) + 1,
  localparam int unsigned MAXV  = (1 << CNT_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             alloc_i,
  input  logic             inc_i,
  input  logic [DEC_W-1:0] dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] sum, rem;

  always_comb begin
    sum = SUM_W'(cnt_q) + SUM_W'(inc_i);
    rem = (SUM_W'(dec_i) >= sum) ? '0 : sum - SUM_W'(dec_i);
    cnt_d = (rem > SUM_W'(MAXV)) ? CNT_W'(MAXV) : rem[CNT_W-1:0];
    if (alloc_i) cnt_d = CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= CNT_W'(INIT);
    else if (flush_i) cnt_q <= CNT_W'(INIT);
    else              cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rcfl_top.sv
module rcfl_top
  import rcfl_pkg::*;
#(
  parameter int unsigned NUM_PREGS = DEF_NUM_PREGS,
  parameter int unsigned LREG_W    = DEF_LREG_W,
  parameter int unsigned REN_W     = DEF_REN_W,
  parameter int unsigned CMT_W     = DEF_CMT_W,
  parameter int unsigned CNT_W     = DEF_CNT_W,
  localparam int unsigned PW        = $clog2(NUM_PREGS),
  localparam int unsigned CW        = $clog2(NUM_PREGS + 1),
  localparam int unsigned DEC_W     = $clog2(CMT_W + 1),
  localparam int unsigned ARCH_REGS = 1 << LREG_W,
  localparam int unsigned MAXV      = (1 << CNT_W) - 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic                          redirect_i,
  input  logic                          walk_i,
  input  logic                          do_alloc_i,
  input  logic [REN_W-1:0]              slot_valid_i,
  input  logic [REN_W-1:0]              slot_wen_i,
  input  logic [REN_W-1:0][LREG_W-1:0]  slot_ldest_i,
  input  logic [REN_W-1:0]              me_valid_i,
  input  logic [REN_W-1:0][PW-1:0]      me_psrc_i,
  output logic                          can_alloc_o,
  output logic [REN_W-1:0][PW-1:0]      pdest_o,
  input  logic [CMT_W-1:0]              rel_valid_i,
  input  logic [CMT_W-1:0][PW-1:0]      rel_new_i,
  input  logic [CMT_W-1:0][PW-1:0]      rel_old_i,
  output logic [NUM_PREGS-1:0]          sat_o
);
  logic [NUM_PREGS-1:0]            reg_free, reg_alloc, reg_inc;
  logic [NUM_PREGS-1:0][DEC_W-1:0] reg_dec;
  logic [REN_W-1:0][PW-1:0]        pick;
  logic [CW-1:0]                   free_cnt;
  logic [REN_W-1:0]                need, slot_alloc, slot_inc;
  logic [CMT_W-1:0][PW-1:0]        rel_tgt;
  logic                            fire;
  rel_sel_e                        rel_sel;

  rcfl_pick #(.NUM_PREGS(NUM_PREGS), .REN_W(REN_W)) u_pick (
    .free_i(reg_free), .pick_o(pick), .free_cnt_o(free_cnt)
  );

  assign can_alloc_o = free_cnt >= CW'(REN_W);
  assign pdest_o     = pick;
  assign fire        = can_alloc_o & do_alloc_i & ~walk_i & ~redirect_i & ~flush_i;
  assign rel_sel     = walk_i ? REL_NEW_DEST : REL_OLD_DEST;

  always_comb begin
    for (int i = 0; i < REN_W; i++) begin
      need[i]       = slot_valid_i[i] & slot_wen_i[i] & (slot_ldest_i[i] != '0);
      slot_alloc[i] = fire & need[i] & ~me_valid_i[i];
      slot_inc[i]   = fire & need[i] & me_valid_i[i];
    end
    for (int c = 0; c < CMT_W; c++)
      rel_tgt[c] = (rel_sel == REL_NEW_DEST) ? rel_new_i[c] : rel_old_i[c];
  end

  for (genvar r = 0; r < NUM_PREGS; r++) begin : g_reg
    logic [CNT_W-1:0] cnt;

    always_comb begin
      reg_alloc[r] = 1'b0;
      reg_inc[r]   = 1'b0;
      reg_dec[r]   = '0;
      for (int i = 0; i < REN_W; i++) begin
        if (slot_alloc[i] && pick[i] == PW'(r))   reg_alloc[r] = 1'b1;
        if (slot_inc[i] && me_psrc_i[i] == PW'(r)) reg_inc[r]  = 1'b1;
      end
      for (int c = 0; c < CMT_W; c++)
        if (rel_valid_i[c] && rel_tgt[c] == PW'(r)) reg_dec[r] = reg_dec[r] + DEC_W'(1);
    end

    rcfl_cnt_cell #(
      .CNT_W(CNT_W), .DEC_W(DEC_W), .INIT((r < ARCH_REGS) ? 1 : 0)
    ) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
      .alloc_i(reg_alloc[r]), .inc_i(reg_inc[r]), .dec_i(reg_dec[r]),
      .cnt_o(cnt)
    );

    assign reg_free[r] = (cnt == '0);
    assign sat_o[r]    = (cnt == CNT_W'(MAXV));
  end
endmodule

// File: rtl/rcfl_chk.sv
module rcfl_chk #(
  parameter int unsigned NUM_PREGS = 64,
  parameter int unsigned LREG_W    = 5,
  parameter int unsigned REN_W     = 4,
  localparam int unsigned PW        = $clog2(NUM_PREGS),
  localparam int unsigned ARCH_REGS = 1 << LREG_W
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     flush_i,
  input logic                     redirect_i,
  input logic                     walk_i,
  input logic                     do_alloc_i,
  input logic                     can_alloc_o,
  input logic [REN_W-1:0][PW-1:0] pdest_o,
  input logic [REN_W-1:0][PW-1:0] me_psrc_i,
  input logic [NUM_PREGS-1:0]     sat_o,
  input logic [NUM_PREGS-1:0]     reg_alloc,
  input logic [REN_W-1:0]         slot_inc
);
  assert_gated_alloc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(can_alloc_o && do_alloc_i) |-> (reg_alloc == '0 && slot_inc == '0));

  assert_walk_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_i |-> (reg_alloc == '0 && slot_inc == '0));

  assert_redirect_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |-> (reg_alloc == '0 && slot_inc == '0));

  assert_flush_restores_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (pdest_o[0] == PW'(ARCH_REGS) && can_alloc_o));

  for (genvar i = 0; i < REN_W; i++) begin : g_slot
    assert_no_inc_saturated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_inc[i] |-> !sat_o[me_psrc_i[i]]);
  end

  for (genvar s = 0; s + 1 < REN_W; s++) begin : g_order
    assert_ascending_pick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      can_alloc_o |-> (pdest_o[s] < pdest_o[s+1]));
  end
endmodule

bind rcfl_top rcfl_chk #(
  .NUM_PREGS(NUM_PREGS), .LREG_W(LREG_W), .REN_W(REN_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .redirect_i(redirect_i),
  .walk_i(walk_i), .do_alloc_i(do_alloc_i), .can_alloc_o(can_alloc_o),
  .pdest_o(pdest_o), .me_psrc_i(me_psrc_i), .sat_o(sat_o),
  .reg_alloc(reg_alloc), .slot_inc(slot_inc)
);

// File: tb/rcfl_top_test.sv
`timescale 1ns/1ps
module rcfl_top_test;
  localparam int NP = 64, LW = 5, RW = 4, CWD = 4, PW = 6, ARCH = 32, MAXC = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic flush, redirect, walk, do_alloc, can_alloc;
  logic [RW-1:0] slot_valid, slot_wen, me_valid;
  logic [RW-1:0][LW-1:0] slot_ldest;
  logic [RW-1:0][PW-1:0] me_psrc, pdest;
  logic [CWD-1:0] rel_valid;
  logic [CWD-1:0][PW-1:0] rel_new, rel_old;
  logic [NP-1:0] sat;

  int mcnt [NP];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rcfl_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush), .redirect_i(redirect),
    .walk_i(walk), .do_alloc_i(do_alloc), .slot_valid_i(slot_valid),
    .slot_wen_i(slot_wen), .slot_ldest_i(slot_ldest), .me_valid_i(me_valid),
    .me_psrc_i(me_psrc), .can_alloc_o(can_alloc), .pdest_o(pdest),
    .rel_valid_i(rel_valid), .rel_new_i(rel_new), .rel_old_i(rel_old), .sat_o(sat)
  );

  function automatic void model_reset();
    for (int r = 0; r < NP; r++) mcnt[r] = (r < ARCH) ? 1 : 0;
  endfunction

  function automatic int free_count();
    int n = 0;
    for (int r = 0; r < NP; r++) if (mcnt[r] == 0) n++;
    return n;
  endfunction

  function automatic int exp_pick(int i);
    int n = 0;
    for (int r = 0; r < NP; r++)
      if (mcnt[r] == 0) begin
        if (n == i) return r;
        n++;
      end
    return 0;
  endfunction

  function automatic void model_step();
    int inc [NP];
    int dec [NP];
    bit al [NP];
    bit fire;
    int v, p;
    if (flush) begin model_reset(); return; end
    for (int r = 0; r < NP; r++) begin inc[r] = 0; dec[r] = 0; al[r] = 0; end
    fire = (free_count() >= RW) && do_alloc && !walk && !redirect;
    for (int i = 0; i < RW; i++)
      if (fire && slot_valid[i] && slot_wen[i] && slot_ldest[i] != 0) begin
        if (me_valid[i]) inc[me_psrc[i]]++;
        else begin p = exp_pick(i); al[p] = 1; end
      end
    for (int c = 0; c < CWD; c++)
      if (rel_valid[c]) dec[walk ? int'(rel_new[c]) : int'(rel_old[c])]++;
    for (int r = 0; r < NP; r++) begin
      if (al[r]) mcnt[r] = 1;
      else begin
        v = mcnt[r] + inc[r] - dec[r];
        if (v < 0) v = 0;
        if (v > MAXC) v = MAXC;
        mcnt[r] = v;
      end
    end
  endfunction

  task automatic check_outputs(string tag);
    logic [NP-1:0] es;
    for (int i = 0; i < RW; i++) begin
      checks++;
      if (int'(pdest[i]) != exp_pick(i)) begin
        errors++;
        $display("FAIL %s R4 pdest[%0d] actual %0d expected %0d", tag, i, pdest[i], exp_pick(i));
      end
    end
    checks++;
    if (can_alloc !== (free_count() >= RW)) begin
      errors++;
      $display("FAIL %s R5 can_alloc actual %0b expected %0b", tag, can_alloc, free_count() >= RW);
    end
    for (int r = 0; r < NP; r++) es[r] = (mcnt[r] == MAXC);
    checks++;
    if (sat !== es) begin
      errors++;
      $display("FAIL %s R7 sat actual %h expected %h", tag, sat, es);
    end
  endtask

  task automatic clear_inputs();
    flush = 0; redirect = 0; walk = 0; do_alloc = 0;
    slot_valid = '0; slot_wen = '0; slot_ldest = '0; me_valid = '0; me_psrc = '0;
    rel_valid = '0; rel_new = '0; rel_old = '0;
  endtask

  task automatic all_slots_need();
    slot_valid = '1; slot_wen = '1;
    for (int i = 0; i < RW; i++) slot_ldest[i] = LW'(i + 1);
  endtask

  task automatic run_cycle(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_outputs(tag);
    clear_inputs();
  endtask

  function automatic int rand_live();
    int r;
    for (int t = 0; t < 16; t++) begin
      r = $urandom_range(1, NP - 1);
      if (mcnt[r] > 0) return r;
    end
    return $urandom_range(0, NP - 1);
  endfunction

  task automatic random_inputs();
    bit used [NP];
    int r;
    for (int k = 0; k < NP; k++) used[k] = 0;
    flush    = ($urandom_range(0, 199) == 0);
    redirect = ($urandom_range(0, 19) == 0);
    walk     = ($urandom_range(0, 9) == 0);
    do_alloc = ($urandom_range(0, 9) != 0);
    for (int i = 0; i < RW; i++) begin
      slot_valid[i] = ($urandom_range(0, 9) != 0);
      slot_wen[i]   = ($urandom_range(0, 7) != 0);
      slot_ldest[i] = LW'($urandom_range(0, ARCH - 1));
      me_valid[i]   = 1'b0;
      if ($urandom_range(0, 3) == 0) begin
        r = rand_live();
        if (mcnt[r] > 0 && mcnt[r] < MAXC && !used[r]) begin
          used[r] = 1; me_valid[i] = 1'b1; me_psrc[i] = PW'(r);
        end
      end
    end
    for (int c = 0; c < CWD; c++) begin
      rel_valid[c] = ($urandom_range(0, 9) < 6);
      rel_new[c] = PW'(rand_live());
      rel_old[c] = ($urandom_range(0, 19) == 0) ? PW'($urandom_range(0, NP - 1)) : PW'(rand_live());
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clear_inputs();
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_outputs("R1_reset");

    // R2: slot0 ldest 0, slot1 no write, slot2 invalid, slot3 needs
    slot_valid = 4'b1011; slot_wen = 4'b1101;
    slot_ldest[0] = 0; slot_ldest[1] = 7; slot_ldest[2] = 3; slot_ldest[3] = 5;
    do_alloc = 1;
    run_cycle("R2_need");

    all_slots_need(); do_alloc = 0;
    run_cycle("R3_no_enable");

    all_slots_need(); do_alloc = 1; me_valid[0] = 1; me_psrc[0] = 5;
    run_cycle("R6_elim");

    slot_valid = 4'b0001; slot_wen = 4'b0001; slot_ldest[0] = 9;
    do_alloc = 1; me_valid[0] = 1; me_psrc[0] = 5;
    run_cycle("R7_saturate");

    rel_valid = 4'b0011; rel_old[0] = 5; rel_old[1] = 5;
    run_cycle("R12_double_release");

    rel_valid = 4'b0001; rel_old[0] = 5;
    run_cycle("R8_release_to_zero");

    rel_valid = 4'b0001; rel_old[0] = 5;
    run_cycle("R13_release_free");

    all_slots_need(); do_alloc = 1; walk = 1;
    rel_valid = 4'b0001; rel_new[0] = 33; rel_old[0] = 7;
    run_cycle("R9_walk");

    all_slots_need(); do_alloc = 1; redirect = 1;
    rel_valid = 4'b0001; rel_old[0] = 34;
    run_cycle("R10_redirect");

    for (int k = 0; k < 12; k++) begin
      all_slots_need(); do_alloc = 1;
      run_cycle("R5_exhaust");
    end

    flush = 1; all_slots_need(); do_alloc = 1;
    rel_valid = 4'b0001; rel_old[0] = 40;
    run_cycle("R11_flush");

    for (int n = 0; n < 3000; n++) begin
      random_inputs();
      run_cycle("random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule